// File: doc/BRIEF.md
# PCIe Root-Port MSI Doorbell Capture

This block sits beside a PCIe root port and turns message-signalled interrupts into a single level interrupt toward the CPU. Software programs a 64-bit doorbell address, a per-vector enable word and a per-vector mask word through a small 32-bit register port. Memory writes that arrive from the link side come in on a separate inbound port.

An inbound write that exactly hits the doorbell is absorbed. Its data word is a vector number, and that number sets one bit of a 32-bit pending word. Every other inbound transaction leaves on the forward port unchanged and in the same cycle, so reads and ordinary writes reach the system bus as usual.

Software acknowledges vectors by writing ones to the pending word. A write toggles the bits under its ones, and the interrupt line drops only once the whole pending word is zero.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After reset, all five registers read zero and `irq_out` is low.
- R2: Offset 0x820 holds doorbell address bits 31:0 and offset 0x824 holds bits 63:32. Each half is written and read back independently of the other.
- R3: The enable (0x828) and mask (0x82C) registers read back what was written. A read of any other offset returns zero. A write to any other offset changes no register.
- R4: An inbound transaction is a doorbell hit when all of these hold: `ib_valid`, `ib_write`, `ib_be`=4'hF, `ib_addr` equal to the doorbell address, and a nonzero enable word. On a hit, data value N (0..31) sets pending bit N only when enable bit N is 1. A hit never appears on the forward port.
- R5: Hit data of 32 or more sets no pending bit.
- R6: `irq_out` goes high on the clock edge that ends a hit cycle if, after the update, any pending bit has a mask bit of 0.
- R7: A hit on a masked vector sets its pending bit (offset 0x830) but does not raise `irq_out`.
- R8: A mask write alone neither raises nor lowers `irq_out`. The next hit is evaluated against the new mask, even a hit whose data sets no bit.
- R9: A register write to pending XORs the written value into it. `irq_out` falls only when the result is zero.
- R10: While the enable word is zero, writes to the doorbell address leave on the forward port and pending is unchanged.
- R11: Inbound reads, and writes with any byte enable clear, pass to the forward port unchanged even at the doorbell address.
- R12: When a pending write and a hit fall in the same cycle, the XOR is applied first and the vector bit is then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, same cycle as `reg_rd_en` |
| ib_valid | input | 1 | Inbound transaction valid |
| ib_write | input | 1 | Inbound transaction is a write |
| ib_addr | input | 64 | Inbound address |
| ib_be | input | 4 | Inbound byte enables |
| ib_data | input | 32 | Inbound write data |
| fwd_valid | output | 1 | Forwarded transaction valid |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_addr | output | 64 | Forwarded address |
| fwd_be | output | 4 | Forwarded byte enables |
| fwd_data | output | 32 | Forwarded data |
| irq_out | output | 1 | Level interrupt toward the CPU |

## Verification
A bad doorbell address or enable word shows in the same cycle as a hit: a doorbell write leaks onto the forward port, or an ordinary write is swallowed. A corrupted pending or mask word shows one edge later, either as `irq_out` rising on a masked vector or as `irq_out` failing to fall once every pending bit has been toggled clear. Register readback exposes the stored state directly on the next read. The bench therefore reads the pending word after every stimulus that could change it.

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl #(
  parameter int REG_AW = 12,
  parameter logic [REG_AW-1:0] OFF_DB_LO  = 12'h820,
  parameter logic [REG_AW-1:0] OFF_DB_HI  = 12'h824,
  parameter logic [REG_AW-1:0] OFF_ENABLE = 12'h828,
  parameter logic [REG_AW-1:0] OFF_MASK   = 12'h82C,
  parameter logic [REG_AW-1:0] OFF_STATUS = 12'h830
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ib_valid,
  input  logic              ib_write,
  input  logic [63:0]       ib_addr,
  input  logic [3:0]        ib_be,
  input  logic [31:0]       ib_data,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [63:0]       fwd_addr,
  output logic [3:0]        fwd_be,
  output logic [31:0]       fwd_data,
  output logic              irq_out
);
  localparam int NVEC = 32;
  localparam int VW   = $clog2(NVEC);

  logic [63:0]     db_base;
  logic [NVEC-1:0] en_q, mask_q, stat_q;
  logic            irq_q;

  logic wr_lo, wr_hi, wr_en, wr_mask, wr_stat;
  assign wr_lo   = reg_wr_en && reg_addr == OFF_DB_LO;
  assign wr_hi   = reg_wr_en && reg_addr == OFF_DB_HI;
  assign wr_en   = reg_wr_en && reg_addr == OFF_ENABLE;
  assign wr_mask = reg_wr_en && reg_addr == OFF_MASK;
  assign wr_stat = reg_wr_en && reg_addr == OFF_STATUS;

  logic hit;
  assign hit = ib_valid && ib_write && (&ib_be) && ib_addr == db_base && (|en_q);

  logic            vec_ok;
  logic [NVEC-1:0] set_vec, stat_xor, stat_nxt;
  logic            irq_nxt;
  assign vec_ok   = ib_data < NVEC;
  assign set_vec  = (hit && vec_ok) ? (en_q & (NVEC'(1) << ib_data[VW-1:0])) : '0;
  assign stat_xor = wr_stat ? (stat_q ^ reg_wdata) : stat_q;
  assign stat_nxt = stat_xor | set_vec;

  always_comb begin
    irq_nxt = irq_q;
    if (hit && |(stat_nxt & ~mask_q)) irq_nxt = 1'b1;
    else if (wr_stat && stat_nxt == '0) irq_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_base <= '0;
      en_q    <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_lo)   db_base[31:0]  <= reg_wdata;
      if (wr_hi)   db_base[63:32] <= reg_wdata;
      if (wr_en)   en_q   <= reg_wdata;
      if (wr_mask) mask_q <= reg_wdata;
      stat_q <= stat_nxt;
      irq_q  <= irq_nxt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd_en) begin
      case (reg_addr)
        OFF_DB_LO:  reg_rdata = db_base[31:0];
        OFF_DB_HI:  reg_rdata = db_base[63:32];
        OFF_ENABLE: reg_rdata = en_q;
        OFF_MASK:   reg_rdata = mask_q;
        OFF_STATUS: reg_rdata = stat_q;
        default:    reg_rdata = '0;
      endcase
    end
  end

  assign fwd_valid = ib_valid && !hit;
  assign fwd_write = ib_write;
  assign fwd_addr  = ib_addr;
  assign fwd_be    = ib_be;
  assign fwd_data  = ib_data;
  assign irq_out   = irq_q;
endmodule

// File: rtl/msi_doorbell_ctrl_chk.sv
module msi_doorbell_ctrl_chk #(
  parameter int REG_AW = 12,
  parameter logic [REG_AW-1:0] OFF_MASK = 12'h82C,
  parameter logic [REG_AW-1:0] OFF_STAT = 12'h830
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic              ib_valid,
  input logic              ib_write,
  input logic              fwd_valid,
  input logic              irq_out,
  input logic [31:0]       en_q
);
  logic swallowed;
  assign swallowed = ib_valid && ib_write && !fwd_valid;

  AST_IRQ_RISE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(swallowed)); // R6

  AST_IRQ_FALL_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_out) |-> $past(reg_wr_en && reg_addr == OFF_STAT)); // R9

  AST_READ_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_valid && !ib_write) |-> fwd_valid); // R11

  AST_IDLE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_valid && en_q == '0) |-> fwd_valid); // R10

  AST_MASK_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFF_MASK && !swallowed) |=> $stable(irq_out)); // R8
endmodule

bind msi_doorbell_ctrl msi_doorbell_ctrl_chk #(
  .REG_AW(REG_AW), .OFF_MASK(OFF_MASK), .OFF_STAT(OFF_STATUS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .ib_valid(ib_valid), .ib_write(ib_write), .fwd_valid(fwd_valid),
  .irq_out(irq_out), .en_q(en_q)
);

// File: tb/sim_msi_doorbell_ctrl.sv
module sim_msi_doorbell_ctrl;
  localparam int CLK_P = 10;
  localparam logic [11:0] A_LO = 12'h820, A_HI = 12'h824, A_EN = 12'h828,
                          A_MK = 12'h82C, A_ST = 12'h830;

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ib_valid = 0, ib_write = 0;
  logic [63:0] ib_addr = 0;
  logic [3:0] ib_be = 0;
  logic [31:0] ib_data = 0;
  logic fwd_valid, fwd_write, irq_out;
  logic [63:0] fwd_addr;
  logic [3:0] fwd_be;
  logic [31:0] fwd_data;

  always #(CLK_P/2) clk = ~clk;

  msi_doorbell_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ib_valid(ib_valid), .ib_write(ib_write), .ib_addr(ib_addr), .ib_be(ib_be),
    .ib_data(ib_data), .fwd_valid(fwd_valid), .fwd_write(fwd_write),
    .fwd_addr(fwd_addr), .fwd_be(fwd_be), .fwd_data(fwd_data), .irq_out(irq_out)
  );

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];
  int tests = 0, fails = 0;

  initial forever begin
    @(negedge clk);
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = sb.pop_front();
      case (it.kind)
        0: got = reg_rdata;
        1: got = {31'd0, irq_out};
        default: got = {31'd0, fwd_valid};
      endcase
      tests++;
      if (got !== it.exp) begin
        fails++;
        $display("FAIL %s got %h exp %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic push(int k, logic [31:0] e, string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr_en = 0;
  endtask

  task automatic reg_rd(logic [11:0] a, logic [31:0] e, string t);
    reg_rd_en = 1; reg_addr = a;
    push(0, e, t);
    cyc();
    reg_rd_en = 0;
  endtask

  task automatic inb(logic [63:0] a, logic [31:0] d, logic [3:0] be, logic wr,
                     logic exp_fwd, string t);
    ib_valid = 1; ib_addr = a; ib_data = d; ib_be = be; ib_write = wr;
    push(2, {31'd0, exp_fwd}, t);
    cyc();
    ib_valid = 0;
  endtask

  task automatic chk_irq(logic e, string t);
    push(1, {31'd0, e}, t);
    cyc();
  endtask

  bit done = 0;
  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  localparam logic [63:0] DB = 64'h0000_0001_FEE0_1000;

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1
    reg_rd(A_LO, 0, "R1 lo");  reg_rd(A_HI, 0, "R1 hi");
    reg_rd(A_EN, 0, "R1 en");  reg_rd(A_MK, 0, "R1 mask");
    reg_rd(A_ST, 0, "R1 status");
    chk_irq(0, "R1 irq");
    // R2
    reg_wr(A_LO, 32'hFEE0_0000);
    reg_wr(A_HI, 32'h0000_0001);
    reg_rd(A_LO, 32'hFEE0_0000, "R2 lo");
    reg_rd(A_HI, 32'h0000_0001, "R2 hi");
    reg_wr(A_LO, 32'hFEE0_1000);
    reg_rd(A_HI, 32'h0000_0001, "R2 hi kept");
    reg_rd(A_LO, 32'hFEE0_1000, "R2 lo new");
    // R10
    inb(DB, 32'd3, 4'hF, 1, 1, "R10 fwd with enable zero");
    reg_rd(A_ST, 0, "R10 status");
    // R3
    reg_wr(A_EN, 32'h8000_00FF);
    reg_wr(A_MK, 32'h0);
    reg_wr(12'h834, 32'hFFFF_FFFF);
    reg_rd(12'h834, 0, "R3 unmapped");
    reg_rd(12'h700, 0, "R3 unmapped2");
    reg_rd(A_EN, 32'h8000_00FF, "R3 enable");
    reg_rd(A_MK, 0, "R3 mask");
    reg_rd(A_LO, 32'hFEE0_1000, "R3 lo untouched");
    // R11
    inb(DB, 32'd2, 4'hF, 0, 1, "R11 read passes");
    inb(DB, 32'd2, 4'h3, 1, 1, "R11 partial passes");
    inb(DB + 4, 32'd2, 4'hF, 1, 1, "R11 other addr");
    reg_rd(A_ST, 0, "R11 status");
    chk_irq(0, "R11 irq");
    // R4 R6
    inb(DB, 32'd3, 4'hF, 1, 0, "R4 hit swallowed");
    chk_irq(1, "R6 irq up");
    reg_rd(A_ST, 32'h8, "R4 status");
    inb(DB, 32'd10, 4'hF, 1, 0, "R4 disabled vector hit");
    reg_rd(A_ST, 32'h8, "R4 disabled vector");
    // R5
    inb(DB, 32'd40, 4'hF, 1, 0, "R5 big vector hit");
    reg_rd(A_ST, 32'h8, "R5 status");
    // R9
    reg_wr(A_ST, 32'h8);
    reg_rd(A_ST, 0, "R9 cleared");
    chk_irq(0, "R9 irq down");
    // R7
    reg_wr(A_MK, 32'h1);
    inb(DB, 32'd0, 4'hF, 1, 0, "R7 hit");
    chk_irq(0, "R7 masked irq");
    reg_rd(A_ST, 32'h1, "R7 status");
    // R8
    reg_wr(A_MK, 32'h0);
    chk_irq(0, "R8 mask alone no rise");
    inb(DB, 32'd40, 4'hF, 1, 0, "R8 eval hit");
    chk_irq(1, "R8 next eval rises");
    reg_wr(A_MK, 32'h1);
    chk_irq(1, "R8 mask alone no fall");
    // R9 partial
    inb(DB, 32'd31, 4'hF, 1, 0, "R9 hit 31");
    reg_rd(A_ST, 32'h8000_0001, "R9 two pending");
    reg_wr(A_ST, 32'h1);
    reg_rd(A_ST, 32'h8000_0000, "R9 xor one");
    chk_irq(1, "R9 irq held");
    reg_wr(A_ST, 32'h8000_0000);
    chk_irq(0, "R9 irq falls at zero");
    // R12
    reg_wr_en = 1; reg_addr = A_ST; reg_wdata = 32'h4;
    ib_valid = 1; ib_write = 1; ib_addr = DB; ib_be = 4'hF; ib_data = 32'd2;
    cyc();
    reg_wr_en = 0; ib_valid = 0;
    chk_irq(1, "R12 irq");
    reg_rd(A_ST, 32'h4, "R12 xor then set");
    cyc();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule